// File: doc/BRIEF.md
# Issue Window Occupancy Tracker

This block keeps the bookkeeping for the slots of an out-of-order issue window. A dispatch port places an instruction, tagged with a sequence number, into the lowest-numbered free slot. The instruction may be flagged as non-speculative. An issue port names a slot and retires it. A release port lets a held non-speculative instruction become eligible, identified by its sequence number. A squash port takes a sequence number and throws out every occupied slot whose instruction is strictly younger.

The block publishes how many slots are free, a full flag, and per-slot masks: occupied, ready to issue, held, and squashed-and-committable. The commit side uses the last mask to drop squashed work. Two sticky error bits record a dispatch into a full window and a release that matched nothing. Operand readiness, the choice of which slot to issue and memory ordering belong to neighbouring logic.

Top module: `issue_window_tracker`

## Requirements
- R1: After reset, `free_count` equals DEPTH, `full` is 0, all four masks are zero, both error bits are 0, and `disp_slot` is 0. `full` is 1 exactly when `free_count` is 0.
- R2: `free_count` always equals DEPTH minus the number of set bits in `occupied_mask`. An accepted dispatch lowers it by one. An issue raises it by one, and both in the same cycle leave it unchanged.
- R3: `disp_slot` shows the lowest-numbered free slot. An accepted dispatch sets that slot's bit in `occupied_mask` on the next cycle.
- R4: A dispatch while `full` is 1 writes no slot and sets the sticky `overflow_err`.
- R5: A squash with sequence number S frees every occupied slot whose sequence number is unsigned-greater than S, and each such slot returns one free entry. Slots with a sequence number equal to or below S keep their place.
- R6: A slot freed by squash has its bit in `commit_mask` set, meaning issued and able to commit. The bit clears when a later dispatch reuses the slot.
- R7: A dispatch with `disp_nonspec`=1 sets the slot's bit in `held_mask` and leaves it clear in `ready_mask`. An issue naming that slot has no effect.
- R8: A release whose sequence number matches a held occupied slot clears its held bit, so the slot shows in `ready_mask`. A held slot that was squashed can no longer be released, and a release of it counts as a miss.
- R9: A release that matches no held occupied slot changes no state and sets the sticky `release_err`.
- R10: In a cycle with `sq_valid`=1, any dispatch, issue and release inputs are ignored.
- R11: An issue naming a slot that is empty or held changes nothing.
- R12: When a squash empties the window, `free_count` returns to DEPTH and the next dispatch lands in slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Dispatch request |
| disp_seq | input | SEQ_W | Sequence number of the dispatched instruction |
| disp_nonspec | input | 1 | Dispatched instruction must wait for release |
| disp_slot | output | IDX_W | Slot the next accepted dispatch will take |
| issue_valid | input | 1 | Issue request |
| issue_slot | input | IDX_W | Slot being issued |
| rel_valid | input | 1 | Release request |
| rel_seq | input | SEQ_W | Sequence number to release |
| sq_valid | input | 1 | Squash request |
| sq_seq | input | SEQ_W | Youngest sequence number that survives the squash |
| free_count | output | CNT_W | Number of free slots |
| full | output | 1 | No free slot |
| occupied_mask | output | DEPTH | Slots holding an instruction |
| ready_mask | output | DEPTH | Occupied slots eligible to issue |
| held_mask | output | DEPTH | Occupied slots waiting for release |
| commit_mask | output | DEPTH | Slots freed by squash, marked committable |
| overflow_err | output | 1 | Sticky: dispatch into a full window |
| release_err | output | 1 | Sticky: release matched no held slot |

## Verification
The bench targets the tie cases of the age compare. A squash number equal to a resident sequence number must keep that slot, so an off-by-one compare would evict it and show up in both the occupancy mask and the free count. Dispatch and issue in the same cycle check the counter arithmetic and the choice of the lowest free slot. A design that recomputed the slot after the issue would land the new entry in the slot being vacated.

Inputs presented alongside a squash, issue of held or empty slots, and a release aimed at a squashed held entry show whether squash takes priority and whether the held set is purged. A design that got these wrong would gain entries during a squash, free a held slot early, or quietly accept a stale release. Overflow must leave the occupancy untouched, and squashing down to empty must bring allocation back to slot 0.

// File: rtl/iw_pkg.sv
package iw_pkg;

  // Next free-slot count from the current count and this cycle's events.
  function automatic int unsigned free_step(int unsigned cur, bit took,
                                            bit gave, int unsigned purged);
    return cur - int'(took) + int'(gave) + purged;
  endfunction

endpackage

// File: rtl/iw_alloc.sv
module iw_alloc #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] occ,
  output logic [IDX_W-1:0] slot,
  output logic             any_free
);

  // Lowest-index free slot; scanned from the top so the lowest wins.
  always_comb begin
    slot     = '0;
    any_free = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!occ[i]) begin
        slot     = IDX_W'(i);
        any_free = 1'b1;
      end
    end
  end

endmodule

// File: rtl/iw_slot.sv
module iw_slot #(
  parameter int SEQ_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  input  logic [SEQ_W-1:0] d_seq,
  input  logic             d_nonspec,
  input  logic             issue_req,
  input  logic             rel_valid,
  input  logic [SEQ_W-1:0] rel_seq,
  input  logic             sq_valid,
  input  logic [SEQ_W-1:0] sq_seq,
  output logic             occupied,
  output logic             held,
  output logic             commit_ok,
  output logic             kill,
  output logic             rel_hit,
  output logic             issue_fire
);

  logic [SEQ_W-1:0] seq_q;
  logic             occ_q, held_q, cmt_q;

  assign kill       = sq_valid && occ_q && (seq_q > sq_seq);
  assign rel_hit    = rel_valid && !sq_valid && occ_q && held_q && (seq_q == rel_seq);
  assign issue_fire = issue_req && occ_q && !held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q  <= '0;
      occ_q  <= 1'b0;
      held_q <= 1'b0;
      cmt_q  <= 1'b0;
    end else if (alloc) begin
      seq_q  <= d_seq;
      occ_q  <= 1'b1;
      held_q <= d_nonspec;
      cmt_q  <= 1'b0;
    end else if (kill) begin
      occ_q  <= 1'b0;
      held_q <= 1'b0;
      cmt_q  <= 1'b1;
    end else if (issue_fire) begin
      occ_q  <= 1'b0;
    end else if (rel_hit) begin
      held_q <= 1'b0;
    end
  end

  assign occupied  = occ_q;
  assign held      = held_q;
  assign commit_ok = cmt_q;

  // Squashed younger entry leaves and becomes committable.
  assert_squash_evicts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> (!occ_q && cmt_q));

  // A held entry survives an issue request aimed at it.
  assert_held_not_issued_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_req && held_q && occ_q && !sq_valid) |=> occ_q);

  // A matching release makes the entry eligible.
  assert_release_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rel_hit |=> (occ_q && !held_q));

endmodule

// File: rtl/iw_freecnt.sv
module iw_freecnt #(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             took,
  input  logic             gave,
  input  logic [CNT_W-1:0] purged,
  output logic [CNT_W-1:0] count,
  output logic             full
);

  import iw_pkg::*;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CNT_W'(DEPTH);
    else        cnt_q <= CNT_W'(free_step(int'(cnt_q), took, gave, int'(purged)));
  end

  assign count = cnt_q;
  assign full  = (cnt_q == '0);

  // Counter never exceeds the window depth.
  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

endmodule

// File: rtl/issue_window_tracker.sv
module issue_window_tracker #(
  parameter int DEPTH = 8,
  parameter int SEQ_W = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             disp_valid,
  input  logic [SEQ_W-1:0] disp_seq,
  input  logic             disp_nonspec,
  output logic [IDX_W-1:0] disp_slot,
  input  logic             issue_valid,
  input  logic [IDX_W-1:0] issue_slot,
  input  logic             rel_valid,
  input  logic [SEQ_W-1:0] rel_seq,
  input  logic             sq_valid,
  input  logic [SEQ_W-1:0] sq_seq,
  output logic [CNT_W-1:0] free_count,
  output logic             full,
  output logic [DEPTH-1:0] occupied_mask,
  output logic [DEPTH-1:0] ready_mask,
  output logic [DEPTH-1:0] held_mask,
  output logic [DEPTH-1:0] commit_mask,
  output logic             overflow_err,
  output logic             release_err
);

  function automatic logic [CNT_W-1:0] ones(logic [DEPTH-1:0] v);
    logic [CNT_W-1:0] n;
    n = '0;
    for (int i = 0; i < DEPTH; i++) n = n + CNT_W'(v[i]);
    return n;
  endfunction

  logic [DEPTH-1:0] occ, held, cmt, kill_v, rel_v, fire_v;
  logic [IDX_W-1:0] alloc_slot;
  logic             any_free;
  logic             disp_ok, disp_bad, rel_miss, issue_go;

  iw_alloc #(.DEPTH(DEPTH)) u_alloc (
    .occ(occ), .slot(alloc_slot), .any_free(any_free)
  );

  assign disp_ok  = disp_valid && !sq_valid && !full;
  assign disp_bad = disp_valid && !sq_valid && full;
  assign rel_miss = rel_valid && !sq_valid && (rel_v == '0);
  assign issue_go = |fire_v;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    iw_slot #(.SEQ_W(SEQ_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .alloc     (disp_ok && (alloc_slot == IDX_W'(g))),
      .d_seq     (disp_seq),
      .d_nonspec (disp_nonspec),
      .issue_req (issue_valid && !sq_valid && (issue_slot == IDX_W'(g))),
      .rel_valid (rel_valid),
      .rel_seq   (rel_seq),
      .sq_valid  (sq_valid),
      .sq_seq    (sq_seq),
      .occupied  (occ[g]),
      .held      (held[g]),
      .commit_ok (cmt[g]),
      .kill      (kill_v[g]),
      .rel_hit   (rel_v[g]),
      .issue_fire(fire_v[g])
    );
  end

  iw_freecnt #(.DEPTH(DEPTH)) u_cnt (
    .clk(clk), .rst_n(rst_n), .took(disp_ok), .gave(issue_go),
    .purged(ones(kill_v)), .count(free_count), .full(full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      overflow_err <= 1'b0;
      release_err  <= 1'b0;
    end else begin
      if (disp_bad) overflow_err <= 1'b1;
      if (rel_miss) release_err  <= 1'b1;
    end
  end

  assign disp_slot     = alloc_slot;
  assign occupied_mask = occ;
  assign held_mask     = held;
  assign ready_mask    = occ & ~held;
  assign commit_mask   = cmt;

  // Incremental counter agrees with the occupancy bits.
  assert_count_matches_R2: assert property (@(posedge clk) disable iff (!rst_n)
    free_count == CNT_W'(DEPTH) - ones(occ));

  // Dispatch into a full window writes nothing and flags the error.
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_bad && !issue_valid) |=> (overflow_err && $stable(occ)));

  // A release that matched nothing is recorded.
  assert_release_miss_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rel_miss |=> release_err);

  // Nothing gains a slot during a squash cycle.
  assert_squash_priority_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sq_valid |=> ($countones(occ) <= $countones($past(occ))));

endmodule

// File: tb/issue_window_tracker_bench.sv
module issue_window_tracker_bench;

  localparam int D  = 4;
  localparam int SW = 8;
  localparam int IW = 2;
  localparam int CW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          disp_valid = 0, disp_nonspec = 0, issue_valid = 0;
  logic          rel_valid = 0, sq_valid = 0;
  logic [SW-1:0] disp_seq = '0, rel_seq = '0, sq_seq = '0;
  logic [IW-1:0] issue_slot = '0;
  logic [IW-1:0] disp_slot;
  logic [CW-1:0] free_count;
  logic          full, overflow_err, release_err;
  logic [D-1:0]  occupied_mask, ready_mask, held_mask, commit_mask;

  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  issue_window_tracker #(.DEPTH(D), .SEQ_W(SW)) u_issue_window_tracker (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_seq(disp_seq),
    .disp_nonspec(disp_nonspec), .disp_slot(disp_slot),
    .issue_valid(issue_valid), .issue_slot(issue_slot),
    .rel_valid(rel_valid), .rel_seq(rel_seq), .sq_valid(sq_valid), .sq_seq(sq_seq),
    .free_count(free_count), .full(full), .occupied_mask(occupied_mask),
    .ready_mask(ready_mask), .held_mask(held_mask), .commit_mask(commit_mask),
    .overflow_err(overflow_err), .release_err(release_err)
  );

  typedef struct packed {
    logic          dv;
    logic [SW-1:0] dseq;
    logic          dns;
    logic          iv;
    logic [IW-1:0] islot;
    logic          rv;
    logic [SW-1:0] rseq;
    logic          sv;
    logic [SW-1:0] sseq;
    logic [CW-1:0] efree;
    logic [D-1:0]  eocc, erdy, eheld, ecom;
    logic          eovf, erel;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    //  dv dseq    ns iv sl    rv rseq   sv sseq   free  occ      rdy      held     com      ov re
    '{1'b1,8'd10,1'b0,1'b0,2'd0,1'b0,8'd0 ,1'b0,8'd0 ,3'd3,4'b0001,4'b0001,4'b0000,4'b0000,1'b0,1'b0},
    '{1'b1,8'd11,1'b1,1'b0,2'd0,1'b0,8'd0 ,1'b0,8'd0 ,3'd2,4'b0011,4'b0001,4'b0010,4'b0000,1'b0,1'b0},
    '{1'b1,8'd12,1'b0,1'b1,2'd1,1'b0,8'd0 ,1'b0,8'd0 ,3'd1,4'b0111,4'b0101,4'b0010,4'b0000,1'b0,1'b0},
    '{1'b1,8'd13,1'b0,1'b1,2'd0,1'b0,8'd0 ,1'b0,8'd0 ,3'd1,4'b1110,4'b1100,4'b0010,4'b0000,1'b0,1'b0},
    '{1'b1,8'd14,1'b0,1'b0,2'd0,1'b0,8'd0 ,1'b0,8'd0 ,3'd0,4'b1111,4'b1101,4'b0010,4'b0000,1'b0,1'b0},
    '{1'b1,8'd15,1'b0,1'b0,2'd0,1'b0,8'd0 ,1'b0,8'd0 ,3'd0,4'b1111,4'b1101,4'b0010,4'b0000,1'b1,1'b0},
    '{1'b0,8'd0 ,1'b0,1'b0,2'd0,1'b1,8'd11,1'b0,8'd0 ,3'd0,4'b1111,4'b1111,4'b0000,4'b0000,1'b1,1'b0},
    '{1'b0,8'd0 ,1'b0,1'b0,2'd0,1'b1,8'd99,1'b0,8'd0 ,3'd0,4'b1111,4'b1111,4'b0000,4'b0000,1'b1,1'b1},
    '{1'b0,8'd0 ,1'b0,1'b1,2'd1,1'b0,8'd0 ,1'b0,8'd0 ,3'd1,4'b1101,4'b1101,4'b0000,4'b0000,1'b1,1'b1},
    '{1'b1,8'd20,1'b0,1'b1,2'd0,1'b0,8'd0 ,1'b1,8'd12,3'd3,4'b0100,4'b0100,4'b0000,4'b1001,1'b1,1'b1},
    '{1'b1,8'd21,1'b1,1'b0,2'd0,1'b0,8'd0 ,1'b0,8'd0 ,3'd2,4'b0101,4'b0100,4'b0001,4'b1000,1'b1,1'b1},
    '{1'b0,8'd0 ,1'b0,1'b0,2'd0,1'b0,8'd0 ,1'b1,8'd12,3'd3,4'b0100,4'b0100,4'b0000,4'b1001,1'b1,1'b1},
    '{1'b0,8'd0 ,1'b0,1'b1,2'd2,1'b0,8'd0 ,1'b0,8'd0 ,3'd4,4'b0000,4'b0000,4'b0000,4'b1001,1'b1,1'b1},
    '{1'b1,8'd30,1'b0,1'b0,2'd0,1'b0,8'd0 ,1'b0,8'd0 ,3'd3,4'b0001,4'b0001,4'b0000,4'b1000,1'b1,1'b1},
    '{1'b0,8'd0 ,1'b0,1'b0,2'd0,1'b0,8'd0 ,1'b1,8'd5 ,3'd4,4'b0000,4'b0000,4'b0000,4'b1001,1'b1,1'b1},
    '{1'b1,8'd31,1'b0,1'b0,2'd0,1'b0,8'd0 ,1'b0,8'd0 ,3'd3,4'b0001,4'b0001,4'b0000,4'b1000,1'b1,1'b1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Bench-side occupancy rule: free slots equal depth minus occupied bits.
  task automatic chk_invariant();
    int pop = 0;
    for (int i = 0; i < D; i++) pop += int'(occupied_mask[i]);
    chk(int'(free_count) == D - pop, "R2 free vs occupancy", int'(free_count), D - pop);
    chk(full == (free_count == 0), "R1 full flag", int'(full), int'(free_count == 0));
  endtask

  task automatic drive(input vec_t v);
    @(negedge clk);
    disp_valid = v.dv;  disp_seq = v.dseq; disp_nonspec = v.dns;
    issue_valid = v.iv; issue_slot = v.islot;
    rel_valid = v.rv;   rel_seq = v.rseq;
    sq_valid = v.sv;    sq_seq = v.sseq;
    @(posedge clk);
    #2;
    disp_valid = 0; issue_valid = 0; rel_valid = 0; sq_valid = 0;
  endtask

  function automatic vec_t idle();
    vec_t v;
    v = '0;
    return v;
  endfunction

  initial begin
    #(8 * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    vec_t v;
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    chk(int'(free_count) == D, "R1 reset free", int'(free_count), D);
    chk(occupied_mask == 0 && commit_mask == 0 && held_mask == 0, "R1 reset masks",
        int'(occupied_mask | commit_mask | held_mask), 0);
    chk(!overflow_err && !release_err, "R1 reset errors", int'({overflow_err, release_err}), 0);
    chk(disp_slot == 0, "R3 reset disp_slot", int'(disp_slot), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // Table: R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 R12
    for (int k = 0; k < NV; k++) begin
      drive(TBL[k]);
      chk(free_count == TBL[k].efree, $sformatf("R2 row%0d free", k), int'(free_count), int'(TBL[k].efree));
      chk(occupied_mask == TBL[k].eocc, $sformatf("R3/R5 row%0d occupied", k), int'(occupied_mask), int'(TBL[k].eocc));
      chk(ready_mask == TBL[k].erdy, $sformatf("R7/R11 row%0d ready", k), int'(ready_mask), int'(TBL[k].erdy));
      chk(held_mask == TBL[k].eheld, $sformatf("R7/R8 row%0d held", k), int'(held_mask), int'(TBL[k].eheld));
      chk(commit_mask == TBL[k].ecom, $sformatf("R6 row%0d commit", k), int'(commit_mask), int'(TBL[k].ecom));
      chk(overflow_err == TBL[k].eovf, $sformatf("R4 row%0d overflow", k), int'(overflow_err), int'(TBL[k].eovf));
      chk(release_err == TBL[k].erel, $sformatf("R9 row%0d release_err", k), int'(release_err), int'(TBL[k].erel));
      chk_invariant();
    end
    // R12: after the emptying squash the dispatch went to slot 0; next is slot 1
    chk(disp_slot == 1, "R12 next slot", int'(disp_slot), 1);

    // Fresh reset, R1 again
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #2;
    chk(int'(free_count) == D && occupied_mask == 0 && commit_mask == 0, "R1 re-reset",
        int'(free_count), D);
    chk(!overflow_err && !release_err, "R1 re-reset errors", int'({overflow_err, release_err}), 0);
    @(negedge clk); rst_n = 1'b1;

    // R10: release presented with a squash is ignored
    v = idle(); v.dv = 1; v.dseq = 8'd50; v.dns = 1; drive(v);
    v = idle(); v.rv = 1; v.rseq = 8'd50; v.sv = 1; v.sseq = 8'd60; drive(v);
    chk(held_mask == 4'b0001, "R10 release ignored in squash", int'(held_mask), 1);
    chk(!release_err, "R10 no miss during squash", int'(release_err), 0);
    // R8: normal release
    v = idle(); v.rv = 1; v.rseq = 8'd50; drive(v);
    chk(ready_mask == 4'b0001 && held_mask == 0, "R8 release frees", int'(ready_mask), 1);
    chk(!release_err, "R8 hit no error", int'(release_err), 0);
    // R8: squashed held entry cannot be released
    v = idle(); v.dv = 1; v.dseq = 8'd70; v.dns = 1; drive(v);
    chk(held_mask == 4'b0010, "R7 second held", int'(held_mask), 2);
    v = idle(); v.sv = 1; v.sseq = 8'd69; drive(v);
    chk(held_mask == 0 && commit_mask == 4'b0010, "R5 held squashed",
        int'({held_mask, commit_mask}), 2);
    v = idle(); v.rv = 1; v.rseq = 8'd70; drive(v);
    chk(release_err, "R8 stale release flagged", int'(release_err), 1);
    drive(idle());
    chk(release_err && occupied_mask == 4'b0001, "R9 sticky and unchanged",
        int'(occupied_mask), 1);
    chk_invariant();

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule